// File: doc/BRIEF.md
# Associativity-Reconfigurable Cache Lookup

This block performs the tag and index lookup for a set-associative cache whose capacity stays fixed while its associativity can be switched at run time. The choices are 16, 8, 4, 2 or 1 ways. The storage is always sixteen physical ways, and every way has its own tag comparator. When associativity is lowered, ways are concatenated into groups. Address bits just above the base (16-way) index then choose which group is searched, so the effective index grows by one bit and the compared tag shrinks by one bit at each halving.

Each tag entry holds a full tag sized for the 16-way case, plus a valid bit and a dirty bit. A read or write strobe returns hit/miss and the physical way one cycle later. On a miss, a line is allocated round-robin inside the active group.

Before any change of associativity the cache must be walked clean. A flush walk visits every entry and emits one writeback request for each dirty line over a valid/ready handshake. It invalidates everything, so a tag left over from the old mapping can never produce a false hit. It then raises `flush_done`. A new associativity code is accepted only while the cache is flushed and idle.

Top module: `assoc_cache_lookup`

## Requirements
- R1: After reset the active mode code is 0 (16 ways), `flush_done` is 1, and `res_valid`, `busy` and `wb_valid` are 0.
- R2: Mode code k selects 16>>k ways: 0 for 16, 1 for 8, 2 for 4, 3 for 2 and 4 for 1. Codes above 4 are taken as 4. The group number g is the lowest k bits of the tag field, which starts at bit OFFSET_W+IDX_W. Only physical ways g*(16>>k) through g*(16>>k)+(16>>k)-1 can hit or be allocated.
- R3: The tag compare ignores the lowest k bits of the stored and requested tag fields. At most one way hits.
- R4: An access presented on a rising edge (`acc_rd` or `acc_wr` high) gives `res_valid` high for the following cycle. That cycle also carries `res_hit` and `res_way`: the hitting way, or the way just allocated on a miss.
- R5: A single 4-bit miss counter, cleared at reset and advanced on every miss, picks the victim. The victim is the group's first way plus (counter mod group size).
- R6: A write hit marks the line dirty. A write miss allocates a dirty line, and a read miss allocates a clean line.
- R7: `flush_start` starts a walk over entries in the order way*SETS+set. Each valid dirty entry drives `wb_valid` with `wb_addr` = {tag field, set, zero offset}. `wb_valid` and `wb_addr` stay stable until `wb_ready`, and the walk takes one entry per cycle otherwise.
- R8: When the walk ends, `flush_done` is 1 and `busy` is 0, every entry is invalid, and later accesses miss.
- R9: `assoc_cfg` is copied to the active mode only in a cycle with `flush_done` high, no walk running, no access strobe and no `flush_start`. Otherwise the active mode holds.
- R10: While `busy` is high, or in a cycle where `flush_start` is high, access strobes are ignored: no result and no allocation.
- R11: Any access that allocates a line clears `flush_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_rd | input | 1 | Read access strobe |
| acc_wr | input | 1 | Write access strobe |
| acc_addr | input | ADDR_W | Access byte address |
| assoc_cfg | input | 3 | Requested mode code |
| assoc_active | output | 3 | Mode code in force |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | Lookup hit |
| res_way | output | 4 | Hitting or allocated physical way |
| flush_start | input | 1 | Start the flush walk |
| busy | output | 1 | Flush walk in progress |
| wb_valid | output | 1 | Writeback request valid |
| wb_ready | input | 1 | Writeback request accepted |
| wb_addr | output | ADDR_W | Line address to write back |
| flush_done | output | 1 | Cache is fully invalid |

## Verification
The bench builds the block with a 16-bit address, a 2-bit offset and a 2-bit base index. This gives four sets of sixteen ways and a 12-bit tag field, small enough that every mode code, every way group and every set is reached with a few dozen accesses each. Tags are drawn from a 64-value space, so hits, conflicts inside a group and wraps of the round-robin counter all occur in every mode. Each flush walk, run with a stalling ready pattern, checks the full dirty-line list in order against an arithmetic model.

// File: rtl/acl_pkg.sv
package acl_pkg;
  localparam int WAYS  = 16;
  localparam int WAY_W = 4;
  localparam logic [2:0] MAX_SHIFT = 3'd4;

  typedef enum logic {FW_IDLE, FW_SCAN} fw_state_t;

  // Mode code to way-count shift; codes beyond direct-mapped saturate.
  function automatic logic [2:0] clamp_shift(input logic [2:0] code);
    return (code > MAX_SHIFT) ? MAX_SHIFT : code;
  endfunction

  function automatic logic [WAY_W:0] group_size(input logic [2:0] sh);
    return (WAY_W + 1)'(WAYS) >> sh;
  endfunction

  function automatic logic [WAY_W-1:0] group_mask(input logic [2:0] sh);
    return WAY_W'(((WAY_W + 1)'(1) << sh) - (WAY_W + 1)'(1));
  endfunction

  function automatic logic way_in_group(input logic [WAY_W-1:0] way,
                                        input logic [WAY_W-1:0] grp,
                                        input logic [2:0] sh);
    return (way >> (3'(WAY_W) - sh)) == grp;
  endfunction

  function automatic logic [WAY_W-1:0] victim_way(input logic [WAY_W-1:0] grp,
                                                  input logic [WAY_W-1:0] cnt,
                                                  input logic [2:0] sh);
    logic [WAY_W-1:0] base;
    logic [WAY_W-1:0] off;
    base = grp << (3'(WAY_W) - sh);
    off  = cnt & WAY_W'(group_size(sh) - (WAY_W + 1)'(1));
    return base | off;
  endfunction
endpackage

// File: rtl/acl_tag_match.sv
module acl_tag_match
  import acl_pkg::*;
#(
  parameter int TAG_W = 22
) (
  input  logic [WAYS-1:0]            set_valid,
  input  logic [WAYS-1:0][TAG_W-1:0] set_tags,
  input  logic [TAG_W-1:0]           look_tag,
  input  logic [WAY_W-1:0]           grp,
  input  logic [2:0]                 sh,
  output logic [WAYS-1:0]            hit_vec
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    logic [TAG_W-1:0] diff;
    assign diff       = set_tags[w] ^ look_tag;
    assign hit_vec[w] = set_valid[w] && way_in_group(WAY_W'(w), grp, sh)
                        && ((diff >> sh) == '0);
  end
endmodule

// File: rtl/acl_victim.sv
module acl_victim
  import acl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic [WAY_W-1:0] grp,
  input  logic [2:0]       sh,
  output logic [WAY_W-1:0] victim
);
  logic [WAY_W-1:0] miss_cnt;

  assign victim = victim_way(grp, miss_cnt, sh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       miss_cnt <= '0;
    else if (advance) miss_cnt <= miss_cnt + 1'b1;
  end
endmodule

// File: rtl/acl_flush_walk.sv
module acl_flush_walk
  import acl_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             clr_done,
  input  logic             ent_valid,
  input  logic             ent_dirty,
  input  logic             wb_ready,
  output logic             busy,
  output logic             wb_req,
  output logic             inv_en,
  output logic [WAY_W-1:0] ptr_way,
  output logic [IDX_W-1:0] ptr_set,
  output logic             done
);
  localparam int PTR_W = WAY_W + IDX_W;

  fw_state_t        state;
  logic [PTR_W-1:0] ptr;

  assign busy    = (state == FW_SCAN);
  assign ptr_way = ptr[PTR_W-1 -: WAY_W];
  assign ptr_set = ptr[IDX_W-1:0];
  assign wb_req  = busy && ent_valid && ent_dirty;
  assign inv_en  = busy && (!wb_req || wb_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= FW_IDLE;
      ptr   <= '0;
      done  <= 1'b1;
    end else if (start && !busy) begin
      state <= FW_SCAN;
      ptr   <= '0;
      done  <= 1'b0;
    end else if (inv_en) begin
      ptr <= ptr + 1'b1;
      if (ptr == '1) begin
        state <= FW_IDLE;
        done  <= 1'b1;
      end
    end else if (clr_done) begin
      done <= 1'b0;
    end
  end
endmodule

// File: rtl/assoc_cache_lookup.sv
module assoc_cache_lookup
  import acl_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 6,
  parameter int IDX_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [2:0]        assoc_cfg,
  output logic [2:0]        assoc_active,
  output logic              res_valid,
  output logic              res_hit,
  output logic [3:0]        res_way,
  input  logic              flush_start,
  output logic              busy,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr,
  output logic              flush_done
);
  localparam int SETS  = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - OFFSET_W - IDX_W;

  logic [TAG_W-1:0] tag_q   [WAYS][SETS];
  logic [SETS-1:0]  valid_q [WAYS];
  logic [SETS-1:0]  dirty_q [WAYS];

  logic [2:0]       sh_q;
  logic [IDX_W-1:0] set_idx;
  logic [TAG_W-1:0] look_tag;
  logic [WAY_W-1:0] grp;
  logic [WAYS-1:0]            set_valid;
  logic [WAYS-1:0][TAG_W-1:0] set_tags;
  logic [WAYS-1:0]  hit_vec;
  logic             hit_any;
  logic [WAY_W-1:0] hit_way;
  logic [WAY_W-1:0] victim;
  logic             acc_go;
  logic             alloc;
  logic             cfg_ok;
  logic             inv_en;
  logic [WAY_W-1:0] fw_way;
  logic [IDX_W-1:0] fw_set;
  logic             unused_ok;

  assign set_idx   = acc_addr[OFFSET_W +: IDX_W];
  assign look_tag  = acc_addr[ADDR_W-1 -: TAG_W];
  assign grp       = look_tag[WAY_W-1:0] & group_mask(sh_q);
  assign unused_ok = &{1'b0, acc_addr[OFFSET_W-1:0]};

  assign acc_go  = (acc_rd || acc_wr) && !busy && !flush_start;
  assign alloc   = acc_go && !hit_any;
  assign cfg_ok  = flush_done && !busy && !flush_start && !acc_rd && !acc_wr;
  assign hit_any = |hit_vec;
  assign assoc_active = sh_q;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      set_valid[w] = valid_q[w][set_idx];
      set_tags[w]  = tag_q[w][set_idx];
    end
  end

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  acl_tag_match #(.TAG_W(TAG_W)) u_match (
    .set_valid(set_valid), .set_tags(set_tags), .look_tag(look_tag),
    .grp(grp), .sh(sh_q), .hit_vec(hit_vec)
  );

  acl_victim u_victim (
    .clk(clk), .rst_n(rst_n), .advance(alloc), .grp(grp), .sh(sh_q),
    .victim(victim)
  );

  acl_flush_walk #(.IDX_W(IDX_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(flush_start), .clr_done(alloc),
    .ent_valid(valid_q[fw_way][fw_set]), .ent_dirty(dirty_q[fw_way][fw_set]),
    .wb_ready(wb_ready), .busy(busy), .wb_req(wb_valid), .inv_en(inv_en),
    .ptr_way(fw_way), .ptr_set(fw_set), .done(flush_done)
  );

  assign wb_addr = {tag_q[fw_way][fw_set], fw_set, OFFSET_W'(0)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_way   <= '0;
      sh_q      <= '0;
    end else begin
      res_valid <= acc_go;
      if (acc_go) begin
        res_hit <= hit_any;
        res_way <= hit_any ? hit_way : victim;
      end
      if (cfg_ok) sh_q <= clamp_shift(assoc_cfg);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WAYS; w++) begin
        valid_q[w] <= '0;
        dirty_q[w] <= '0;
      end
    end else if (inv_en) begin
      valid_q[fw_way][fw_set] <= 1'b0;
      dirty_q[fw_way][fw_set] <= 1'b0;
    end else if (acc_go) begin
      if (hit_any) begin
        if (acc_wr) dirty_q[hit_way][set_idx] <= 1'b1;
      end else begin
        valid_q[victim][set_idx] <= 1'b1;
        dirty_q[victim][set_idx] <= acc_wr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc) tag_q[victim][set_idx] <= look_tag;
  end
endmodule

// File: rtl/acl_checker.sv
module acl_checker
  import acl_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 6,
  parameter int IDX_W    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_rd,
  input logic              acc_wr,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [2:0]        assoc_active,
  input logic              res_valid,
  input logic              res_hit,
  input logic [3:0]        res_way,
  input logic              busy,
  input logic              wb_valid,
  input logic              wb_ready,
  input logic [ADDR_W-1:0] wb_addr,
  input logic              flush_done,
  input logic [WAYS-1:0]   hit_vec,
  input logic              acc_go
);
  logic [WAY_W-1:0] grp_now, grp_q;
  logic [2:0]       sh_q;

  assign grp_now = WAY_W'(acc_addr >> (OFFSET_W + IDX_W)) & group_mask(assoc_active);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q <= '0;
      sh_q  <= '0;
    end else begin
      grp_q <= grp_now;
      sh_q  <= assoc_active;
    end
  end

  assert_single_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_go |-> $onehot0(hit_vec));

  assert_way_in_group_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> way_in_group(res_way, grp_q, sh_q));

  assert_wb_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr));

  assert_cfg_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(assoc_active) |-> $past(flush_done) && !$past(busy));

  assert_miss_after_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && $past(flush_done) |-> !res_hit);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |-> !busy);

  assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (acc_rd || acc_wr) |=> !res_valid);
endmodule

bind assoc_cache_lookup acl_checker #(
  .ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr),
  .acc_addr(acc_addr), .assoc_active(assoc_active), .res_valid(res_valid),
  .res_hit(res_hit), .res_way(res_way), .busy(busy), .wb_valid(wb_valid),
  .wb_ready(wb_ready), .wb_addr(wb_addr), .flush_done(flush_done),
  .hit_vec(hit_vec), .acc_go(acc_go)
);

// File: tb/assoc_cache_lookup_bench.sv
module assoc_cache_lookup_bench;
  localparam int AW = 16, OFF = 2, IDX = 2, SETS = 4;
  localparam int TSH = OFF + IDX;

  logic clk = 0, rst_n = 0;
  logic acc_rd = 0, acc_wr = 0, flush_start = 0, wb_ready = 0;
  logic [AW-1:0] acc_addr = '0;
  logic [2:0] assoc_cfg = 0, assoc_active;
  logic res_valid, res_hit, busy, wb_valid, flush_done;
  logic [3:0] res_way;
  logic [AW-1:0] wb_addr;

  int tests = 0, fails = 0;
  bit finished = 0;

  // reference model, built from the requirements
  int  mtag [16][SETS];
  bit  mval [16][SETS];
  bit  mdty [16][SETS];
  int  mcnt = 0;
  int  mk = 0;
  int  lcg = 12345;

  always #2 clk = ~clk;

  assoc_cache_lookup #(.ADDR_W(AW), .OFFSET_W(OFF), .IDX_W(IDX)) u_assoc_cache_lookup (
    .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .assoc_cfg(assoc_cfg), .assoc_active(assoc_active), .res_valid(res_valid),
    .res_hit(res_hit), .res_way(res_way), .flush_start(flush_start), .busy(busy),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .flush_done(flush_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int next_rand();
    lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
    return lcg >> 8;
  endfunction

  task automatic access(input bit wr, input int a);
    int set, tagf, grp, gsz, base, ew;
    bit eh;
    set  = (a >> OFF) & (SETS - 1);
    tagf = (a >> TSH) & 12'hfff;
    grp  = tagf & ((1 << mk) - 1);
    gsz  = 16 >> mk;
    base = grp * gsz;
    eh = 0; ew = 0;
    for (int w = base; w < base + gsz; w++)
      if (mval[w][set] && (((mtag[w][set] ^ tagf) >> mk) == 0)) begin
        eh = 1; ew = w;
      end
    if (eh) begin
      if (wr) mdty[ew][set] = 1;
    end else begin
      ew = base + (mcnt % gsz);
      mcnt = (mcnt + 1) % 16;
      mval[ew][set] = 1; mdty[ew][set] = wr; mtag[ew][set] = tagf;
    end
    @(negedge clk);
    acc_rd = !wr; acc_wr = wr; acc_addr = AW'(a);
    @(negedge clk);
    acc_rd = 0; acc_wr = 0;
    check(res_valid == 1, "R4 result valid", res_valid, 1);
    check(res_hit == eh, "R3 hit", res_hit, eh);
    check(res_way == ew, eh ? "R2 hit way" : "R5 victim way", res_way, ew);
  endtask

  task automatic run_flush(input bit probe);
    int exp_addr [$];
    int idx = 0, cyc = 0;
    for (int w = 0; w < 16; w++)
      for (int s = 0; s < SETS; s++)
        if (mval[w][s] && mdty[w][s]) exp_addr.push_back((mtag[w][s] << TSH) | (s << OFF));
    @(negedge clk); flush_start = 1;
    @(negedge clk); flush_start = 0;
    check(busy == 1, "R7 walk running", busy, 1);
    while (!flush_done && cyc < 1000) begin
      if (probe && cyc == 3) begin acc_rd = 1; acc_addr = 16'h0010; end
      if (probe && cyc == 4) begin
        acc_rd = 0;
        check(res_valid == 0, "R10 access ignored while busy", res_valid, 0);
      end
      wb_ready = (cyc % 3) != 1;
      if (wb_valid && wb_ready) begin
        if (idx < exp_addr.size())
          check(wb_addr == AW'(exp_addr[idx]), "R7 writeback address", wb_addr, exp_addr[idx]);
        else check(0, "R7 extra writeback", idx, exp_addr.size());
        idx++;
      end
      @(negedge clk);
      cyc++;
    end
    acc_rd = 0; wb_ready = 0;
    check(idx == exp_addr.size(), "R6 R7 dirty line count", idx, exp_addr.size());
    check(flush_done == 1 && busy == 0, "R8 flush done", flush_done, 1);
    for (int w = 0; w < 16; w++)
      for (int s = 0; s < SETS; s++) begin mval[w][s] = 0; mdty[w][s] = 0; end
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < 16; w++)
      for (int s = 0; s < SETS; s++) begin mval[w][s] = 0; mdty[w][s] = 0; mtag[w][s] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(assoc_active == 0, "R1 mode", assoc_active, 0);
    check(flush_done == 1, "R1 flush_done", flush_done, 1);
    check(res_valid == 0 && busy == 0 && wb_valid == 0, "R1 idle", res_valid, 0);

    for (int k = 0; k <= 4; k++) begin
      run_flush(k == 1);
      @(negedge clk); assoc_cfg = 3'(k);
      @(negedge clk); @(negedge clk);
      check(assoc_active == k, "R9 mode accepted", assoc_active, k);
      mk = k;
      for (int n = 0; n < 60; n++) begin
        int r = next_rand();
        access(r[0], ((r >> 1) % 64) << TSH | (((r >> 8) % SETS) << OFF) | ((r >> 11) & 3));
        if (n == 0) begin
          check(res_hit == 0, "R8 miss after flush", res_hit, 0);
          check(flush_done == 0, "R11 allocation clears done", flush_done, 0);
        end
      end
      // repeat a known address: hit on second use
      access(1, (13 << TSH) | (2 << OFF));
      access(0, (13 << TSH) | (2 << OFF));
      check(res_hit == 1, "R6 repeat hit", res_hit, 1);
      // group-bit variation: tag differs only above group bits -> miss
      access(0, ((13 ^ (1 << k)) << TSH) | (2 << OFF));
      // request a change while not flushed: must hold
      @(negedge clk); assoc_cfg = 3'((k + 1) % 5);
      repeat (2) @(negedge clk);
      check(assoc_active == k, "R9 change held while dirty", assoc_active, k);
      assoc_cfg = 3'(k);
    end

    // clamp of out-of-range code, then post-flush miss
    run_flush(0);
    @(negedge clk); assoc_cfg = 3'd7;
    @(negedge clk); @(negedge clk);
    check(assoc_active == 4, "R2 code clamp", assoc_active, 4);
    mk = 4;
    access(0, (13 << TSH) | (2 << OFF));
    check(res_hit == 0, "R8 miss after final flush", res_hit, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule